// File: doc/BRIEF.md
# Sample Delay Tap Trainer

This block searches for a sampling delay setting that lets read data be captured reliably at a high serial clock rate. A start pulse begins training. The block first asks an external flash command issuer for a 3-byte identification read while the delay is off, and keeps that answer as the reference. It then moves through the delay taps from zero upward. At each tap it repeats the identification read and compares the answer with the reference. The passing window found this way gives the final tap.

The result is a tap value, a valid flag and a fail flag, presented with a one-cycle done pulse. The block also drives the delay control word that goes to the physical delay line. A fail result tells the host to drop to its safe clock rate. A reference that looks like an empty bus is reported as no device, and training is skipped. Switching clock rates and the delay line itself are handled outside this block.

Top module: `dly_tap_trainer`

## Requirements
- R1: After start, the first request (`cmdReq` high) carries opcode 0x9F on `cmdOpcode` and is issued with `dlyCtrl` = 0. The answer becomes the reference. `cmdData[23:16]` is the first byte received and `cmdData[15:8]` is the second.
- R2: If the first two reference bytes are both 0xFF or both 0x00, the block finishes with `noDevice`=1, `tapValid`=0, `tapFail`=0 and `dlyCtrl`=0. No further request is issued.
- R3: The sweep requests start at tap 0 and rise in steps of 10.
- R4: When the next step would go past the maximum tap, the last tap tested is exactly the maximum tap. The sweep ends after testing the maximum tap.
- R5: The left edge is the first tap whose answer equals all 24 reference bits. After a match has been seen, the first mismatching tap ends the sweep, and the right edge is the tap tested just before it.
- R6: Training is valid only if some tap matched and right − left ≥ 80.
- R7: On a valid result with left = 0 and right below the maximum tap, the chosen tap is (right × 2) / 5, with truncation.
- R8: On any other valid result, the chosen tap is left + (right − left) / 2, with truncation.
- R9: `dlyCtrl` holds the tap in bits [8:0] and an enable at bit 15. A tap of 0 gives an all-zero word. During the sweep it shows the tap under test, and after a valid result it shows the chosen tap.
- R10: `extRange`, sampled at start, selects a maximum tap of 0x1FF when 1 and 0xFF when 0.
- R11: On failure, `tapFail`=1, `tapValid`=0, `tapOut`=0 and `dlyCtrl`=0.
- R12: `done` is a one-cycle pulse, and the results are already on the outputs in that cycle. A start that arrives while `busy` is high has no effect.
- R13: `cmdReq` stays high until `cmdDone` is seen. Each done pulse carries its answer on `cmdData`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin training (pulse) |
| extRange | input | 1 | 1: maximum tap 0x1FF, 0: maximum tap 0xFF |
| cmdReq | output | 1 | Identification read request to the issuer |
| cmdOpcode | output | 8 | Opcode for the request (0x9F) |
| cmdDone | input | 1 | Issuer completion pulse |
| cmdData | input | 24 | The three bytes read, first byte in [23:16] |
| busy | output | 1 | Training in progress |
| done | output | 1 | One-cycle completion pulse |
| dlyCtrl | output | 16 | Delay control word: enable bit 15, tap in [8:0] |
| tapOut | output | 9 | Chosen tap (0 unless valid) |
| tapValid | output | 1 | Training succeeded |
| tapFail | output | 1 | Training failed; lower the clock |
| noDevice | output | 1 | Reference looked like an empty bus |

## Verification
The hardest case to reach is a mismatch on the forced final step at the maximum tap. That tap is not a multiple of the step, so the right edge has to be the tap tested before it, not the maximum minus the step. The bench's read responder passes only the taps inside a chosen window. It places the window's upper end at 510, so the last regular step matches and the forced tap 511 fails. Other windows are placed to exercise the left-at-zero bias, the all-pass case that ends at the maximum, a width of exactly 80, a width just below 80, and the no-device patterns. A second start is pulsed in the middle of one sweep.

// File: rtl/dly_train_pkg.sv
package dly_train_pkg;
  typedef struct packed {
    logic init;      // clear results, latch range
    logic capRef;    // store reference answer
    logic sample;    // evaluate a sweep answer, advance tap
    logic finalize;  // compute result
    logic testing;   // show tap under test on the control word
  } dpCmd_t;
endpackage

// File: rtl/dly_train_ctrl.sv
module dly_train_ctrl
  import dly_train_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   start,
  input  logic   cmdDone,
  input  logic   refAbsent,
  input  logic   lastStep,
  output dpCmd_t cmd,
  output logic   cmdReq,
  output logic   busy,
  output logic   done
);
  typedef enum logic [2:0] {
    S_IDLE, S_REF, S_CHK, S_GAP, S_SWEEP, S_CALC, S_FIN
  } state_t;

  state_t state, stateNxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNxt;
  end

  always_comb begin
    stateNxt = state;
    cmd      = '0;
    cmdReq   = 1'b0;
    done     = 1'b0;
    unique case (state)
      S_IDLE: if (start) begin
        cmd.init = 1'b1;
        stateNxt = S_REF;
      end
      S_REF: begin
        cmdReq = 1'b1;
        if (cmdDone) begin
          cmd.capRef = 1'b1;
          stateNxt   = S_CHK;
        end
      end
      S_CHK: stateNxt = refAbsent ? S_FIN : S_GAP;
      S_GAP: begin
        cmd.testing = 1'b1;
        stateNxt    = S_SWEEP;
      end
      S_SWEEP: begin
        cmdReq      = 1'b1;
        cmd.testing = 1'b1;
        if (cmdDone) begin
          cmd.sample = 1'b1;
          stateNxt   = lastStep ? S_CALC : S_GAP;
        end
      end
      S_CALC: begin
        cmd.finalize = 1'b1;
        stateNxt     = S_FIN;
      end
      S_FIN: begin
        done     = 1'b1;
        stateNxt = S_IDLE;
      end
      default: stateNxt = S_IDLE;
    endcase
  end

  assign busy = (state != S_IDLE);

  a_r13_req_hold: assert property (@(posedge clk) disable iff (!rstN)
    cmdReq && !cmdDone |=> cmdReq);
  a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  a_r12_no_restart: assert property (@(posedge clk) disable iff (!rstN)
    busy && !done |=> !(state == S_REF && $past(state) != S_REF && $past(state) != S_IDLE));
endmodule

// File: rtl/dly_train_dp.sv
module dly_train_dp
  import dly_train_pkg::*;
#(
  parameter int TAP_W      = 9,
  parameter int CTRL_W     = 16,
  parameter int EN_BIT     = 15,
  parameter int ID_W       = 24,
  parameter int STEP       = 10,
  parameter int MIN_WIN    = 80,
  parameter int MAX_NARROW = 255,
  parameter int MAX_WIDE   = 511
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCmd_t            cmd,
  input  logic              extRange,
  input  logic [ID_W-1:0]   cmdData,
  output logic              refAbsent,
  output logic              lastStep,
  output logic [CTRL_W-1:0] dlyCtrl,
  output logic [TAP_W-1:0]  tapOut,
  output logic              tapValid,
  output logic              tapFail,
  output logic              noDevice
);
  localparam logic [TAP_W-1:0] MAX_N = TAP_W'(MAX_NARROW);
  localparam logic [TAP_W-1:0] MAX_W = TAP_W'(MAX_WIDE);
  localparam logic [TAP_W:0]   STEP_V = (TAP_W+1)'(STEP);
  localparam logic [TAP_W-1:0] MIN_V = TAP_W'(MIN_WIN);

  logic [ID_W-1:0]  refId;
  logic [TAP_W-1:0] maxTap, curTap, leftE, rightE, tapR;
  logic             seen, absentR, validR, failR;

  function automatic logic [CTRL_W-1:0] fmtCtrl(input logic [TAP_W-1:0] t);
    logic [CTRL_W-1:0] v;
    v = '0;
    v[TAP_W-1:0] = t;
    if (t != '0) v[EN_BIT] = 1'b1;
    return v;
  endfunction

  logic match;
  assign match    = (cmdData == refId);
  assign lastStep = (seen && !match) || (curTap == maxTap);

  logic [TAP_W:0]   stepSum;
  logic [TAP_W-1:0] nextTap;
  assign stepSum = {1'b0, curTap} + STEP_V;
  assign nextTap = (stepSum > {1'b0, maxTap}) ? maxTap : stepSum[TAP_W-1:0];

  logic [TAP_W-1:0] width, half, twoFifths, pick;
  logic [TAP_W+1:0] dbl;
  logic             winOk;
  assign width     = rightE - leftE;
  assign dbl       = {1'b0, width, 1'b0};
  assign twoFifths = TAP_W'(dbl / (TAP_W+2)'(5));
  assign half      = width >> 1;
  assign winOk     = seen && (width >= MIN_V);
  assign pick      = (leftE == '0 && rightE < maxTap) ? leftE + twoFifths
                                                      : leftE + half;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refId <= '0; maxTap <= '0; curTap <= '0; leftE <= '0; rightE <= '0;
      tapR <= '0; seen <= 1'b0; absentR <= 1'b0; validR <= 1'b0; failR <= 1'b0;
    end else begin
      if (cmd.init) begin
        maxTap  <= extRange ? MAX_W : MAX_N;
        curTap  <= '0;
        leftE   <= '0;
        rightE  <= '0;
        tapR    <= '0;
        seen    <= 1'b0;
        absentR <= 1'b0;
        validR  <= 1'b0;
        failR   <= 1'b0;
      end
      if (cmd.capRef) begin
        refId   <= cmdData;
        absentR <= (cmdData[ID_W-1 -: 16] == 16'hFFFF) ||
                   (cmdData[ID_W-1 -: 16] == 16'h0000);
      end
      if (cmd.sample && !(seen && !match)) begin
        if (match) begin
          if (!seen) leftE <= curTap;
          rightE <= curTap;
          seen   <= 1'b1;
        end
        if (curTap != maxTap) curTap <= nextTap;
      end
      if (cmd.finalize) begin
        validR <= winOk;
        failR  <= !winOk;
        tapR   <= winOk ? pick : '0;
      end
    end
  end

  assign refAbsent = absentR;
  assign noDevice  = absentR;
  assign tapOut    = tapR;
  assign tapValid  = validR;
  assign tapFail   = failR;
  assign dlyCtrl   = fmtCtrl(cmd.testing ? curTap : tapR);

  a_r6_valid_window: assert property (@(posedge clk) disable iff (!rstN)
    tapValid |-> (rightE - leftE) >= MIN_V);
  a_r3_step: assert property (@(posedge clk) disable iff (!rstN)
    cmd.sample && !lastStep |=> (curTap - $past(curTap)) == TAP_W'(STEP) || curTap == maxTap);
  a_r9_tap_bound: assert property (@(posedge clk) disable iff (!rstN)
    dlyCtrl[TAP_W-1:0] <= maxTap);
  a_r11_fail_zero: assert property (@(posedge clk) disable iff (!rstN)
    tapFail |-> dlyCtrl == '0 && !tapValid && tapOut == '0);
endmodule

// File: rtl/dly_tap_trainer.sv
module dly_tap_trainer
  import dly_train_pkg::*;
#(
  parameter int TAP_W      = 9,
  parameter int CTRL_W     = 16,
  parameter int EN_BIT     = 15,
  parameter int ID_W       = 24,
  parameter int STEP       = 10,
  parameter int MIN_WIN    = 80,
  parameter int MAX_NARROW = 255,
  parameter int MAX_WIDE   = 511,
  parameter logic [7:0] ID_OPCODE = 8'h9F
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              extRange,
  output logic              cmdReq,
  output logic [7:0]        cmdOpcode,
  input  logic              cmdDone,
  input  logic [ID_W-1:0]   cmdData,
  output logic              busy,
  output logic              done,
  output logic [CTRL_W-1:0] dlyCtrl,
  output logic [TAP_W-1:0]  tapOut,
  output logic              tapValid,
  output logic              tapFail,
  output logic              noDevice
);
  dpCmd_t cmd;
  logic   refAbsent, lastStep;

  assign cmdOpcode = ID_OPCODE;

  dly_train_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .cmdDone(cmdDone),
    .refAbsent(refAbsent), .lastStep(lastStep), .cmd(cmd),
    .cmdReq(cmdReq), .busy(busy), .done(done)
  );

  dly_train_dp #(
    .TAP_W(TAP_W), .CTRL_W(CTRL_W), .EN_BIT(EN_BIT), .ID_W(ID_W),
    .STEP(STEP), .MIN_WIN(MIN_WIN), .MAX_NARROW(MAX_NARROW), .MAX_WIDE(MAX_WIDE)
  ) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .extRange(extRange), .cmdData(cmdData),
    .refAbsent(refAbsent), .lastStep(lastStep), .dlyCtrl(dlyCtrl),
    .tapOut(tapOut), .tapValid(tapValid), .tapFail(tapFail), .noDevice(noDevice)
  );
endmodule

// File: tb/tb_dly_tap_trainer.sv
module tb_dly_tap_trainer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        extRange = 1'b0;
  logic        cmdReq, busy, done, tapValid, tapFail, noDevice;
  logic [7:0]  cmdOpcode;
  logic        cmdDone = 1'b0;
  logic [23:0] cmdData = '0;
  logic [15:0] dlyCtrl;
  logic [8:0]  tapOut;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  int winLo, winHi, reqIdx;
  logic [23:0] refIdG;
  int gotTaps[$];

  always #5 clk = ~clk;

  dly_tap_trainer dut (
    .clk(clk), .rstN(rstN), .start(start), .extRange(extRange),
    .cmdReq(cmdReq), .cmdOpcode(cmdOpcode), .cmdDone(cmdDone), .cmdData(cmdData),
    .busy(busy), .done(done), .dlyCtrl(dlyCtrl), .tapOut(tapOut),
    .tapValid(tapValid), .tapFail(tapFail), .noDevice(noDevice)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit inWin(input int t);
    return (t >= winLo) && (t <= winHi);
  endfunction

  // watchdog
  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    end
  end

  // read responder: answers each request after a short latency
  initial begin
    forever begin
      @(negedge clk);
      if (cmdReq) begin
        logic [23:0] ans;
        int t;
        t = dlyCtrl[15] ? int'(dlyCtrl[8:0]) : 0;
        if (reqIdx == 0) begin
          check(cmdOpcode == 8'h9F, "R1 opcode", cmdOpcode, 8'h9F);
          check(dlyCtrl == 16'h0, "R1 delay off at reference", dlyCtrl, 0);
          ans = refIdG;
        end else begin
          gotTaps.push_back(t);
          ans = inWin(t) ? refIdG : (refIdG ^ 24'h000100);
        end
        reqIdx++;
        repeat (3) begin
          @(negedge clk);
          check(cmdReq, "R13 request held", cmdReq, 1);
        end
        cmdDone = 1'b1;
        cmdData = ans;
        @(negedge clk);
        cmdDone = 1'b0;
        cmdData = '0;
      end
    end
  end

  task automatic run(input bit ext, input int lo, input int hi, input logic [23:0] id,
                     input bit twice, input string name);
    int maxT, l, r, expTap, t;
    bit found, expValid, expAbsent;
    int expTaps[$];
    maxT = ext ? 511 : 255;
    expAbsent = (id[23:8] == 16'hFFFF) || (id[23:8] == 16'h0000);
    found = 0; l = 0; r = 0;
    if (!expAbsent) begin
      t = 0;
      forever begin
        bit m;
        m = (t >= lo) && (t <= hi);
        expTaps.push_back(t);
        if (found && !m) break;
        if (m) begin
          if (!found) l = t;
          r = t;
          found = 1;
        end
        if (t == maxT) break;
        t = (t + 10 > maxT) ? maxT : t + 10;
      end
    end
    expValid = !expAbsent && found && (r - l >= 80);
    expTap = !expValid ? 0 : ((l == 0 && r < maxT) ? (r - l) * 2 / 5 : l + (r - l) / 2);

    winLo = lo; winHi = hi; refIdG = id; reqIdx = 0;
    gotTaps.delete();
    extRange = ext;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    extRange = ~ext;  // ignored after start (R10)
    if (twice) begin
      repeat (40) @(negedge clk);
      check(busy, "R12 busy mid-sweep", busy, 1);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (!done) @(negedge clk);
    check(noDevice == expAbsent, {"R2 noDevice ", name}, noDevice, expAbsent);
    check(tapValid == expValid, {"R6 valid ", name}, tapValid, expValid);
    check(tapFail == (!expValid && !expAbsent), {"R11 fail ", name}, tapFail, !expValid && !expAbsent);
    check(int'(tapOut) == expTap, {"R7 R8 tap ", name}, tapOut, expTap);
    check(dlyCtrl == (expTap == 0 ? 16'h0 : (16'h8000 | 16'(expTap))),
          {"R9 final control word ", name}, dlyCtrl, expTap == 0 ? 0 : (32'h8000 | expTap));
    check(gotTaps.size() == expTaps.size(), {"R3 R4 R5 sweep length ", name},
          gotTaps.size(), expTaps.size());
    for (int i = 0; i < expTaps.size() && i < gotTaps.size(); i++)
      check(gotTaps[i] == expTaps[i], {"R3 R4 R5 tap order ", name}, gotTaps[i], expTaps[i]);
    @(negedge clk);
    check(!done, "R12 done one cycle", done, 0);
    check(!busy, "R12 idle after done", busy, 0);
    repeat (10) @(negedge clk);
    check(!cmdReq && reqIdx == expTaps.size() + 1, {"R2 R13 no extra requests ", name},
          reqIdx, expTaps.size() + 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(!busy && !done && !cmdReq, "reset idle", busy, 0);
    check(dlyCtrl == 0 && tapOut == 0, "R9 reset control word", dlyCtrl, 0);
    check(!tapValid && !tapFail && !noDevice, "reset flags", tapValid, 0);

    run(1'b0, 30, 200, 24'hC84017, 1'b0, "mid window");            // R8: 115
    run(1'b0, 0, 120, 24'hEF4018, 1'b0, "left at zero");           // R7: 48
    run(1'b0, 0, 255, 24'h9D7018, 1'b0, "all pass narrow");        // R4 R8: 127
    run(1'b0, 40, 120, 24'h1F2233, 1'b0, "width exactly 80");      // R6: 80
    run(1'b1, 100, 170, 24'h204015, 1'b0, "width 70");             // R11
    run(1'b1, 600, 700, 24'h204015, 1'b0, "never matches");        // R4 R11
    run(1'b1, 300, 510, 24'hC22019, 1'b0, "mismatch at max");      // R5 R10: 405
    run(1'b1, 300, 511, 24'hC22019, 1'b0, "match at max");         // R10: 405
    run(1'b0, 0, 255, 24'hFFFF12, 1'b0, "absent ones");            // R2
    run(1'b0, 0, 255, 24'h0000AB, 1'b0, "absent zeros");           // R2
    run(1'b0, 30, 200, 24'hC84017, 1'b1, "restart ignored");       // R12

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule